// File: doc/BRIEF.md
# Zero-Latency Systolic 2-D FIR Filter

This block filters a raster-ordered image stream with a non-recursive two-dimensional kernel of order N. One signed pixel enters per enabled clock and the filtered pixel for that same position leaves in the same cycle. Pixels arrive row by row, each row holding `LINE_LEN` samples. The kernel holds (N+1)×(N+1) static signed coefficients. Positions above the first row and left of column 0 are taken as zero.

Internally the array is a set of N+1 parallel column slices, one per horizontal tap offset. Each slice is a chain of dual-tap elements above a single-tap base element. Each dual-tap element adds two vertical taps to a partial sum that one row earlier came down from the element above. Row delays are line buffers `LINE_LEN` deep, and column delays are single registers chained across the slices. There is one multiplier per coefficient. Sums are carried exactly in a widened accumulator and then rounded and saturated once at the output.

Top module: `fir2d_systolic`

## Requirements
- R1: After synchronous active-high reset all delay storage reads as zero and the raster position is row 0, column 0. With `in_pix` = 0 and `in_valid` = 0, `out_pix` is 0 and `out_valid` is 0.
- R2: Latency is zero. `out_valid` equals `in_valid` in every cycle, and `out_pix` in a valid cycle is the result for the pixel presented in that same cycle, starting with the first pixel after reset.
- R3: For the pixel at row n, column m, the exact sum is the sum over i,j in 0..N of a(i,j)·x(n−i, m−j). Here a(i,j) is the signed `COEF_W`-bit field of `coef` starting at bit (i·(N+1)+j)·`COEF_W`, with i the vertical (row) offset and j the horizontal (column) offset.
- R4: Samples from rows before row 0 of the current frame (the frame starts at reset) count as zero.
- R5: Samples at columns left of column 0 count as zero. The tail of the previous row never enters column 0 of the next row, and the column counter wraps from `LINE_LEN`−1 to 0.
- R6: Cycles with `in_valid` low change no stored state, whatever value `in_pix` carries. Results after a gap equal those of the same stream without the gap.
- R7: Rounding adds 2^(`FRAC`−1) to the exact sum and then shifts it arithmetically right by `FRAC` bits.
- R8: A rounded value above 32767 is output as 32767, and one below −32768 is output as −32768.
- R9: The accumulator holds (N+1)² full-scale products without wrapping, so all-extreme inputs of either sign saturate to the correct rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the raster frame |
| coef | input | (ORDER+1)²·COEF_W | Static kernel coefficients, a(i,j) at field i·(ORDER+1)+j |
| in_valid | input | 1 | Input pixel is valid; enables every storage stage |
| in_pix | input | DATA_W | Signed input pixel in raster order |
| out_valid | output | 1 | Output pixel is valid (same cycle as input) |
| out_pix | output | DATA_W | Signed filtered, rounded and saturated pixel |

## Verification
The assertions assume that `coef` is held constant while pixels stream, that every frame begins with a reset, and that `in_valid` alone marks real samples. The stimulus changes coefficients only while reset is asserted, and starts each frame with a reset. During idle cycles it drives deliberately misleading junk on `in_pix`, so any leakage into the stored state would show up in later outputs. The frames cover random pixels, impulses placed at the first and last column, sparse gaps, small values around the rounding midpoint, and extreme values of both signs that drive the accumulator toward its bound.

// File: rtl/fir2d_pkg.sv
package fir2d_pkg;

  // number of dual-tap elements needed to cover vertical taps 1..order
  function automatic int unsigned pair_count(input int unsigned order);
    return (order + 1) / 2;
  endfunction

  // guard bits for summing 'terms' products without overflow
  function automatic int unsigned guard_bits(input int unsigned terms);
    return (terms > 1) ? $clog2(terms) : 1;
  endfunction

endpackage

// File: rtl/fir2d_line.sv
module fir2d_line #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic             wrapped;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (en) mem[ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wrapped <= 1'b0;
    end else if (en) begin
      if (ptr == PTR_W'(DEPTH - 1)) begin
        ptr     <= '0;
        wrapped <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // entry at ptr was written DEPTH enabled cycles ago; empty until first wrap
  assign dout = wrapped ? mem[ptr] : '0;

  a_r6_line_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(ptr) && $stable(wrapped)));

  a_r4_line_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr < PTR_W'(DEPTH) || DEPTH == (1 << PTR_W));

endmodule

// File: rtl/fir2d_pe_pair.sv
module fir2d_pe_pair #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned ACC_W = 36
) (
  input  logic signed [DW-1:0]    x_lo,
  input  logic signed [DW-1:0]    x_hi,
  input  logic signed [CW-1:0]    c_lo,
  input  logic signed [CW-1:0]    c_hi,
  input  logic        [ACC_W-1:0] sum_in,
  output logic        [ACC_W-1:0] sum_out
);

  localparam int unsigned PROD_W = DW + CW;

  logic signed [PROD_W-1:0] p_lo;
  logic signed [PROD_W-1:0] p_hi;
  logic        [ACC_W-1:0]  e_lo;
  logic        [ACC_W-1:0]  e_hi;

  assign p_lo = c_lo * x_lo;
  assign p_hi = c_hi * x_hi;
  assign e_lo = {{(ACC_W - PROD_W){p_lo[PROD_W-1]}}, p_lo};
  assign e_hi = {{(ACC_W - PROD_W){p_hi[PROD_W-1]}}, p_hi};

  assign sum_out = e_lo + e_hi + sum_in;

endmodule

// File: rtl/fir2d_slice.sv
module fir2d_slice
  import fir2d_pkg::*;
#(
  parameter int unsigned ORDER    = 2,
  parameter int unsigned LINE_LEN = 8,
  parameter int unsigned DW       = 16,
  parameter int unsigned CW       = 16,
  parameter int unsigned ACC_W    = 36
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         en,
  input  logic [(pair_count(ORDER)+1)*DW-1:0]          x_flat,
  input  logic [(ORDER+1)*CW-1:0]                      c_flat,
  output logic [ACC_W-1:0]                             col_sum
);

  localparam int unsigned K      = pair_count(ORDER);
  localparam int unsigned PROD_W = DW + CW;

  // chain[k] : partial sum produced by dual-tap element k
  // held[k]  : same sum, one row later
  logic [ACC_W-1:0] chain [1:K];
  logic [ACC_W-1:0] held  [1:K+1];

  assign held[K+1] = '0;

  for (genvar k = 1; k <= K; k++) begin : g_pair
    logic signed [CW-1:0] c_hi;
    if (2 * k <= ORDER) begin : g_hi
      assign c_hi = c_flat[(2*k)*CW +: CW];
    end else begin : g_tie
      assign c_hi = '0;   // tap beyond the kernel when ORDER is odd
    end

    fir2d_pe_pair #(.DW(DW), .CW(CW), .ACC_W(ACC_W)) u_pe (
      .x_lo    (x_flat[(k-1)*DW +: DW]),
      .x_hi    (x_flat[k*DW +: DW]),
      .c_lo    (c_flat[(2*k-1)*CW +: CW]),
      .c_hi    (c_hi),
      .sum_in  (held[k+1]),
      .sum_out (chain[k])
    );

    fir2d_line #(.W(ACC_W), .DEPTH(LINE_LEN)) u_row_dly (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .din  (chain[k]),
      .dout (held[k])
    );
  end

  // base element: tap 0 of the current row plus the delayed chain
  logic signed [PROD_W-1:0] p0;
  logic signed [CW-1:0]     c0;
  logic signed [DW-1:0]     x0;
  assign c0 = c_flat[0 +: CW];
  assign x0 = x_flat[0 +: DW];
  assign p0 = c0 * x0;
  assign col_sum = {{(ACC_W - PROD_W){p0[PROD_W-1]}}, p0} + held[1];

endmodule

// File: rtl/fir2d_systolic.sv
module fir2d_systolic
  import fir2d_pkg::*;
#(
  parameter int unsigned ORDER    = 2,
  parameter int unsigned LINE_LEN = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned FRAC     = 15
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [(ORDER+1)*(ORDER+1)*COEF_W-1:0]         coef,
  input  logic                                          in_valid,
  input  logic signed [DATA_W-1:0]                      in_pix,
  output logic                                          out_valid,
  output logic signed [DATA_W-1:0]                      out_pix
);

  localparam int unsigned TAPS   = ORDER + 1;
  localparam int unsigned K      = pair_count(ORDER);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned ACC_W  = PROD_W + guard_bits(TAPS * TAPS);
  localparam int unsigned COL_W  = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);

  // ---------------- raster column position ----------------
  logic [COL_W-1:0] col;

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
    end else if (in_valid) begin
      col <= (col == COL_W'(LINE_LEN - 1)) ? '0 : col + 1'b1;
    end
  end

  // ---------------- shared vertical input taps ----------------
  logic signed [DATA_W-1:0]   x_tap [0:K];
  logic [(K+1)*DATA_W-1:0]    x_flat;

  assign x_tap[0] = in_pix;

  for (genvar k = 1; k <= K; k++) begin : g_xline
    fir2d_line #(.W(DATA_W), .DEPTH(LINE_LEN)) u_xdly (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .din  (x_tap[k-1]),
      .dout (x_tap[k])
    );
  end

  for (genvar k = 0; k <= K; k++) begin : g_xflat
    assign x_flat[k*DATA_W +: DATA_W] = x_tap[k];
  end

  // ---------------- column slices ----------------
  logic [TAPS*COEF_W-1:0] col_coef [TAPS];
  logic [ACC_W-1:0]       slice_sum [TAPS];

  for (genvar j = 0; j < TAPS; j++) begin : g_slice
    for (genvar i = 0; i < TAPS; i++) begin : g_cf
      assign col_coef[j][i*COEF_W +: COEF_W] = coef[(i*TAPS + j)*COEF_W +: COEF_W];
    end

    fir2d_slice #(
      .ORDER(ORDER), .LINE_LEN(LINE_LEN), .DW(DATA_W), .CW(COEF_W), .ACC_W(ACC_W)
    ) u_slice (
      .clk     (clk),
      .rst     (rst),
      .en      (in_valid),
      .x_flat  (x_flat),
      .c_flat  (col_coef[j]),
      .col_sum (slice_sum[j])
    );
  end

  // ---------------- horizontal chain (one register per column tap) ----------------
  logic [ACC_W-1:0] acc  [0:ORDER];
  logic [ACC_W-1:0] creg [1:ORDER];

  assign acc[ORDER] = slice_sum[ORDER];

  for (genvar j = 0; j < ORDER; j++) begin : g_hchain
    // at column 0 the previous column belongs to another row: drop it
    assign acc[j] = slice_sum[j] + ((col != '0) ? creg[j+1] : '0);
  end

  for (genvar j = 1; j <= ORDER; j++) begin : g_creg
    always_ff @(posedge clk) begin
      if (rst)           creg[j] <= '0;
      else if (in_valid) creg[j] <= acc[j];
    end
  end

  // ---------------- round and saturate ----------------
  logic signed [ACC_W-1:0] rounded;
  logic signed [ACC_W-1:0] shifted;
  logic                    in_range;

  assign rounded  = $signed(acc[0] + HALF);
  assign shifted  = rounded >>> FRAC;
  assign in_range = (&shifted[ACC_W-1:DATA_W-1]) || !(|shifted[ACC_W-1:DATA_W-1]);

  always_comb begin
    if (in_range)                out_pix = shifted[DATA_W-1:0];
    else if (shifted[ACC_W-1])   out_pix = {1'b1, {(DATA_W-1){1'b0}}};
    else                         out_pix = {1'b0, {(DATA_W-1){1'b1}}};
  end

  assign out_valid = in_valid;

  // ---------------- assertions ----------------
  a_r6_col_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(col));

  a_r5_col_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && col == COL_W'(LINE_LEN - 1)) |=> col == '0);

  a_r5_col_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && col != COL_W'(LINE_LEN - 1)) |=> col == $past(col) + 1'b1);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (acc[0][ACC_W-1] == acc[0][ACC_W-2]));

endmodule

// File: tb/fir2d_systolic_tb.sv
module fir2d_systolic_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 2;
  localparam int M    = 5;
  localparam int FRAC = 4;
  localparam int TAPS = N + 1;
  localparam int ROWS = 8;

  logic                         clk = 1'b0;
  logic                         rst = 1'b1;
  logic [TAPS*TAPS*16-1:0]      coef;
  logic                         in_valid = 1'b0;
  logic signed [15:0]           in_pix = '0;
  logic                         out_valid;
  logic signed [15:0]           out_pix;

  fir2d_systolic #(
    .ORDER(N), .LINE_LEN(M), .DATA_W(16), .COEF_W(16), .FRAC(FRAC)
  ) u_dut (
    .clk(clk), .rst(rst), .coef(coef), .in_valid(in_valid),
    .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  int    a   [TAPS][TAPS];
  int    img [ROWS][M];
  int    r, c;
  int    expq [$];
  string tagq [$];

  task automatic load_coef();
    for (int i = 0; i < TAPS; i++)
      for (int j = 0; j < TAPS; j++)
        coef[(i*TAPS + j)*16 +: 16] = 16'(a[i][j]);
  endtask

  function automatic int model();
    longint s = 0;
    for (int i = 0; i < TAPS; i++)
      for (int j = 0; j < TAPS; j++)
        if (r - i >= 0 && c - j >= 0)
          s += longint'(a[i][j]) * longint'(img[r-i][c-j]);
    s = (s + (longint'(1) << (FRAC - 1))) >>> FRAC;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic do_reset();
    in_valid = 1'b0;
    in_pix   = '0;
    rst      = 1'b1;
    load_coef();
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < M; j++) img[i][j] = 0;
    r = 0; c = 0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // driver: present one pixel and push its expected result
  task automatic send(input int v, input string tag);
    in_valid = 1'b1;
    in_pix   = 16'(v);
    img[r][c] = v;
    expq.push_back(model());
    tagq.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_pix   = 16'sh7ABC;  // junk while idle
    c++;
    if (c == M) begin c = 0; r++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid !== in_valid) begin
        errors++;
        $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, in_valid);
      end
      if (out_valid) begin
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected output actual=%0d expected=none", out_pix);
        end else begin
          int    e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          checks++;
          if (int'(out_pix) != e) begin
            errors++;
            $display("FAIL %s out_pix actual=%0d expected=%0d", t, out_pix, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    // R1: reset state
    a = '{'{16, -8, 4}, '{3, 32, -5}, '{-7, 2, 11}};
    do_reset();
    @(negedge clk);
    checks++;
    if (out_pix !== 16'sd0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset out actual=%0d/%0b expected=0/0", out_pix, out_valid);
    end
    #1;
    @(posedge clk); #1;

    // R3 R4 R5: random frame; first pixel exercises R2 zero latency
    send(123, "R2");
    for (int k = 1; k < 4 * M; k++)
      send(($urandom(seed) % 401) - 200, "R3");

    // R4 R5: impulse at first and last column
    do_reset();
    for (int k = 0; k < 4 * M; k++)
      send((k == 0) ? 16 : ((k == 2*M - 1) ? 48 : 0), (k % M == 0) ? "R5" : "R4");

    // R6: sparse stream with junk during gaps
    a = '{'{-12, 5, 9}, '{6, -3, 14}, '{1, 20, -9}};
    do_reset();
    for (int k = 0; k < 4 * M; k++) begin
      send(($urandom(seed) % 1001) - 500, "R6");
      idle(k % 3);
    end

    // R7: rounding around the midpoint
    a = '{'{1, 0, 0}, '{0, 0, 0}, '{0, 0, 0}};
    do_reset();
    send(8, "R7");  send(-8, "R7"); send(-9, "R7"); send(7, "R7");
    send(24, "R7"); send(-24, "R7"); send(23, "R7"); send(-25, "R7");

    // R8 R9: extremes of both signs
    a = '{'{32767, 32767, 32767}, '{32767, 32767, 32767}, '{32767, 32767, 32767}};
    do_reset();
    for (int k = 0; k < 3 * M; k++) send(32767, "R8");
    a = '{'{-32768, -32768, -32768}, '{-32768, -32768, -32768}, '{-32768, -32768, -32768}};
    do_reset();
    for (int k = 0; k < 3 * M; k++) send(-32768, "R9");
    do_reset();
    for (int k = 0; k < 3 * M; k++) send(32767, "R9");

    idle(2);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2 pending results actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule